// File: doc/BRIEF.md
# Interleaved DRAM Page Decoder

This block sits on the memory path and sorts every physical address into one of two destinations: the on-board DRAM, or the external bus. It works on 4 KB pages. The controller can split its DRAM into two or four banks that alternate page by page. A few bits of a control byte pick the interleave scheme. A 5-bit size-mode index picks one row of a fixed 32-row table, and that row gives the size of each bank.

In an interleaved scheme, the low page-number bits select the bank. The remaining upper bits give the page number inside that bank. The page is on-board only when that local page lies below the bank's size. When no interleave scheme is selected, the whole space is on-board. Three windows override this bounds test:

- The legacy window from A0000h to FFFFFh is never claimed.
- The 15–16 MB window follows a control bit.
- The top megabyte of the address space can be pushed to the external bus with a separate enable.

The initialization code chooses the mode index. It picks the table row with the largest total that still fits in the installed memory, and this block only consumes that index. The result is registered, so it appears one clock after the address.

Top module: `dram_page_decoder`

## Requirements
- R1: While `rst_n` is low, `int_hit` is 0 and `bank` is 0. The reset is asynchronous.
- R2: The `int_hit` and `bank` outputs reflect the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: The scheme is chosen by `ctrl[7:3]`. The value 5'b11101 selects 4-way interleave and 5'b11111 selects 2-way interleave. Any other value selects flat decoding: `bank` is 0 and every page outside the override windows is on-board, whatever the value of `mode`.
- R4: In 4-way interleave, `bank` = `addr[13:12]` and the local page = `addr >> 14`. The page is on-board when the local page × 4 KB is less than the selected bank's size.
- R5: In 2-way interleave, `bank` = {0, `addr[12]`} and the local page = `addr >> 13`. The page is on-board under the same bounds rule.
- R6: Bank sizes come from a 32-row table indexed by `mode`. The rows include:
  - mode 1: banks 0–3 are 512 KB each;
  - mode 5: bank 0 is 1024 KB and the other banks are 0;
  - mode 13: bank 0 is 1024 KB, bank 1 is 8192 KB, banks 2 and 3 are 0;
  - mode 17: banks 0–3 are 2048 KB each;
  - mode 31: banks 0 and 1 are 32768 KB, banks 2 and 3 are 0.
- R7: Addresses from A0000h to FFFFFh always give `int_hit` = 0. The bank number is still computed as usual.
- R8: In the 15–16 MB window (`addr[25:20]` = 15), `int_hit` = !`ctrl[2]`. This holds in every scheme and ignores the bank bounds. R7 takes precedence over this rule.
- R9: When `hole_en` is 1, the top megabyte (`addr[25:20]` all ones) gives `int_hit` = 0. When `hole_en` is 0, that megabyte decodes normally. R7 takes precedence over this rule, and this rule takes precedence over R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (26) | Physical byte address |
| ctrl | input | 8 | Control byte: [7:3] interleave scheme, [2] 15–16 MB to external bus |
| mode | input | 5 | Bank size table row |
| hole_en | input | 1 | Send the top megabyte to the external bus |
| int_hit | output | 1 | Registered: 1 = on-board DRAM, 0 = external bus |
| bank | output | 2 | Registered bank number |

## Verification
In both interleave schemes, pages are placed on both sides of a bank limit: the last local page inside the bank and the first page past it. This shows that the comparison uses the page count of the selected bank and is not off by one. Rows with zero-sized banks and rows with unequal bank sizes show that `bank` selects the table column. Addresses just inside and just outside each override window are tried with the control bit and the enable in both states. Some of these addresses also fail the bounds test or hit two windows at once, which exposes the override priority. The flat-scheme cases use control bytes close to the interleave codes, which shows that only those two exact codes turn interleaving on.

// File: rtl/dram_page_decoder.sv
module dram_page_decoder #(
  parameter int ADDR_W    = 26,
  parameter int PAGE_BITS = 12,
  parameter int MB_BITS   = 20,
  parameter int LEGACY_LO = 'h000A0000,
  parameter int LEGACY_HI = 'h000FFFFF,
  parameter int MID_MB    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ctrl,
  input  logic [4:0]        mode,
  input  logic              hole_en,
  output logic              int_hit,
  output logic [1:0]        bank
);

  localparam int MBW    = ADDR_W - MB_BITS;
  localparam int SH4    = PAGE_BITS + 2;
  localparam int SH2    = PAGE_BITS + 1;

  function automatic logic [63:0] row_kb(input logic [4:0] m);
    logic [15:0] b0, b1, b2, b3;
    case (m)
      5'd0:  {b0, b1, b2, b3} = {16'd512,   16'd512,   16'd0,    16'd0};
      5'd1:  {b0, b1, b2, b3} = {16'd512,   16'd512,   16'd512,  16'd512};
      5'd2:  {b0, b1, b2, b3} = {16'd512,   16'd512,   16'd2048, 16'd0};
      5'd3:  {b0, b1, b2, b3} = {16'd512,   16'd512,   16'd2048, 16'd2048};
      5'd4:  {b0, b1, b2, b3} = {16'd512,   16'd512,   16'd8192, 16'd0};
      5'd5:  {b0, b1, b2, b3} = {16'd1024,  16'd0,     16'd0,    16'd0};
      5'd6:  {b0, b1, b2, b3} = {16'd1024,  16'd1024,  16'd0,    16'd0};
      5'd7:  {b0, b1, b2, b3} = {16'd1024,  16'd1024,  16'd2048, 16'd0};
      5'd8:  {b0, b1, b2, b3} = {16'd1024,  16'd1024,  16'd2048, 16'd2048};
      5'd9:  {b0, b1, b2, b3} = {16'd1024,  16'd1024,  16'd8192, 16'd0};
      5'd10: {b0, b1, b2, b3} = {16'd1024,  16'd1024,  16'd8192, 16'd8192};
      5'd11: {b0, b1, b2, b3} = {16'd1024,  16'd2048,  16'd0,    16'd0};
      5'd12: {b0, b1, b2, b3} = {16'd1024,  16'd2048,  16'd2048, 16'd0};
      5'd13: {b0, b1, b2, b3} = {16'd1024,  16'd8192,  16'd0,    16'd0};
      5'd14: {b0, b1, b2, b3} = {16'd2048,  16'd0,     16'd0,    16'd0};
      5'd15: {b0, b1, b2, b3} = {16'd2048,  16'd2048,  16'd0,    16'd0};
      5'd16: {b0, b1, b2, b3} = {16'd2048,  16'd2048,  16'd2048, 16'd0};
      5'd17: {b0, b1, b2, b3} = {16'd2048,  16'd2048,  16'd2048, 16'd2048};
      5'd18: {b0, b1, b2, b3} = {16'd2048,  16'd2048,  16'd8192, 16'd0};
      5'd19: {b0, b1, b2, b3} = {16'd2048,  16'd2048,  16'd8192, 16'd8192};
      5'd20: {b0, b1, b2, b3} = {16'd2048,  16'd8192,  16'd0,    16'd0};
      5'd21: {b0, b1, b2, b3} = {16'd2048,  16'd8192,  16'd8192, 16'd0};
      5'd22: {b0, b1, b2, b3} = {16'd2048,  16'd8192,  16'd8192, 16'd8192};
      5'd23: {b0, b1, b2, b3} = {16'd4096,  16'd0,     16'd0,    16'd0};
      5'd24: {b0, b1, b2, b3} = {16'd4096,  16'd4096,  16'd0,    16'd0};
      5'd25: {b0, b1, b2, b3} = {16'd4096,  16'd4096,  16'd8192, 16'd8192};
      5'd26: {b0, b1, b2, b3} = {16'd4096,  16'd8192,  16'd0,    16'd0};
      5'd27: {b0, b1, b2, b3} = {16'd8192,  16'd0,     16'd0,    16'd0};
      5'd28: {b0, b1, b2, b3} = {16'd8192,  16'd8192,  16'd0,    16'd0};
      5'd29: {b0, b1, b2, b3} = {16'd8192,  16'd8192,  16'd8192, 16'd0};
      5'd30: {b0, b1, b2, b3} = {16'd8192,  16'd8192,  16'd8192, 16'd8192};
      default: {b0, b1, b2, b3} = {16'd32768, 16'd32768, 16'd0,    16'd0};
    endcase
    return {b3, b2, b1, b0};
  endfunction

  wire unused_ctrl = ^ctrl[1:0];

  wire way4 = (ctrl[7:3] == 5'b11101);
  wire way2 = (ctrl[7:3] == 5'b11111);

  wire [1:0] bank_d = way4 ? addr[SH4-1:PAGE_BITS] :
                      way2 ? {1'b0, addr[PAGE_BITS]} : 2'd0;

  wire [31:0] local_pg = way4 ? 32'(addr >> SH4) : 32'(addr >> SH2);

  logic [63:0] row;
  logic [15:0] size_kb;
  always_comb begin
    row     = row_kb(mode);
    size_kb = row[{bank_d, 4'b0000} +: 16];
  end

  wire [31:0] size_pg  = 32'(size_kb) >> (PAGE_BITS - 10);
  wire        in_bank  = local_pg < size_pg;

  wire legacy = (addr >= ADDR_W'(LEGACY_LO)) && (addr <= ADDR_W'(LEGACY_HI));
  wire top_mb = hole_en && (&addr[ADDR_W-1:MB_BITS]);
  wire mid_mb = (addr[ADDR_W-1:MB_BITS] == MBW'(MID_MB));

  logic hit_d;
  always_comb begin
    if (legacy)             hit_d = 1'b0;
    else if (top_mb)        hit_d = 1'b0;
    else if (mid_mb)        hit_d = !ctrl[2];
    else if (way4 || way2)  hit_d = in_bank;
    else                    hit_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_hit <= 1'b0;
      bank    <= 2'd0;
    end else begin
      int_hit <= hit_d;
      bank    <= bank_d;
    end
  end

endmodule

// File: rtl/dram_page_decoder_chk.sv
module dram_page_decoder_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        ctrl,
  input logic              hole_en,
  input logic              int_hit,
  input logic [1:0]        bank
);

  wire c_w4   = ctrl[7:3] == 5'b11101;
  wire c_w2   = ctrl[7:3] == 5'b11111;
  wire c_leg  = addr >= ADDR_W'(32'h000A0000) && addr < ADDR_W'(32'h00100000);
  wire c_top  = hole_en && addr[ADDR_W-1:20] == {(ADDR_W-20){1'b1}};
  wire c_mid  = addr[ADDR_W-1:20] == (ADDR_W-20)'(15);

  always @(posedge clk)
    if (!rst_n) begin
      AST_RESET_ZERO: assert (!int_hit && bank == 2'd0) else $error("reset state"); // R1
    end

  AST_LEGACY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    c_leg |=> !int_hit); // R7

  AST_TOP_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_leg && c_top) |=> !int_hit); // R9

  AST_MID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_leg && !c_top && c_mid) |=> (int_hit == !$past(ctrl[2]))); // R8

  AST_BANK_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    c_w4 |=> (bank == $past(addr[13:12]))); // R4

  AST_BANK_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    c_w2 |=> (bank == {1'b0, $past(addr[12])})); // R5

  AST_FLAT_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_w4 && !c_w2 && !c_leg && !c_top && !c_mid) |=> (int_hit && bank == 2'd0)); // R3

endmodule

bind dram_page_decoder dram_page_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ctrl(ctrl),
  .hole_en(hole_en), .int_hit(int_hit), .bank(bank)
);

// File: tb/sim_dram_page_decoder.sv
module sim_dram_page_decoder;

  typedef struct packed {
    logic [25:0] a;
    logic [7:0]  c;
    logic [4:0]  m;
    logic        h;
    logic        ei;
    logic [1:0]  eb;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t V [NV] = '{
    '{26'h0000000, 8'hE8, 5'd1,  1'b0, 1'b1, 2'd0, 8'd4}, // R4
    '{26'h0001000, 8'hE8, 5'd1,  1'b0, 1'b1, 2'd1, 8'd4}, // R4
    '{26'h0003000, 8'hE8, 5'd1,  1'b0, 1'b1, 2'd3, 8'd4}, // R4
    '{26'h01FE000, 8'hE8, 5'd1,  1'b0, 1'b1, 2'd2, 8'd4}, // R4 last page in bank
    '{26'h0201000, 8'hE8, 5'd1,  1'b0, 1'b0, 2'd1, 8'd4}, // R4 first page past
    '{26'h0001000, 8'hE8, 5'd5,  1'b0, 1'b0, 2'd1, 8'd6}, // R6 empty bank
    '{26'h03FC000, 8'hE8, 5'd5,  1'b0, 1'b1, 2'd0, 8'd6}, // R6
    '{26'h0400000, 8'hE8, 5'd5,  1'b0, 1'b0, 2'd0, 8'd6}, // R6
    '{26'h1FFD000, 8'hE8, 5'd31, 1'b0, 1'b1, 2'd1, 8'd6}, // R6
    '{26'h0001000, 8'hF8, 5'd13, 1'b0, 1'b1, 2'd1, 8'd5}, // R5
    '{26'h0200000, 8'hF8, 5'd13, 1'b0, 1'b0, 2'd0, 8'd5}, // R5
    '{26'h01FE000, 8'hF8, 5'd13, 1'b0, 1'b1, 2'd0, 8'd5}, // R5
    '{26'h1001000, 8'hF8, 5'd13, 1'b0, 1'b0, 2'd1, 8'd5}, // R5
    '{26'h07D1000, 8'hF8, 5'd13, 1'b0, 1'b1, 2'd1, 8'd5}, // R5
    '{26'h03FF000, 8'hF8, 5'd17, 1'b0, 1'b1, 2'd1, 8'd6}, // R6
    '{26'h0400000, 8'hF8, 5'd17, 1'b0, 1'b0, 2'd0, 8'd6}, // R6
    '{26'h3000000, 8'h00, 5'd0,  1'b0, 1'b1, 2'd0, 8'd3}, // R3
    '{26'h2345000, 8'hE0, 5'd9,  1'b0, 1'b1, 2'd0, 8'd3}, // R3
    '{26'h00A0000, 8'h00, 5'd0,  1'b0, 1'b0, 2'd0, 8'd7}, // R7
    '{26'h00FF000, 8'hE8, 5'd31, 1'b0, 1'b0, 2'd3, 8'd7}, // R7
    '{26'h009F000, 8'h00, 5'd0,  1'b0, 1'b1, 2'd0, 8'd7}, // R7
    '{26'h0100000, 8'h00, 5'd0,  1'b0, 1'b1, 2'd0, 8'd7}, // R7
    '{26'h0F00000, 8'h04, 5'd0,  1'b0, 1'b0, 2'd0, 8'd8}, // R8
    '{26'h0F00000, 8'h00, 5'd0,  1'b0, 1'b1, 2'd0, 8'd8}, // R8
    '{26'h0FFF000, 8'hEC, 5'd1,  1'b0, 1'b0, 2'd3, 8'd8}, // R8
    '{26'h0F01000, 8'hE8, 5'd1,  1'b0, 1'b1, 2'd1, 8'd8}, // R8 overrides bounds
    '{26'h1000000, 8'h04, 5'd0,  1'b0, 1'b1, 2'd0, 8'd8}, // R8
    '{26'h3F00000, 8'h00, 5'd0,  1'b1, 1'b0, 2'd0, 8'd9}, // R9
    '{26'h3F00000, 8'h00, 5'd0,  1'b0, 1'b1, 2'd0, 8'd9}, // R9
    '{26'h3EFF000, 8'h00, 5'd0,  1'b1, 1'b1, 2'd0, 8'd9}, // R9
    '{26'h3FFF000, 8'hE8, 5'd31, 1'b1, 1'b0, 2'd3, 8'd9}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] addr = '0;
  logic [7:0]  ctrl = '0;
  logic [4:0]  mode = '0;
  logic        hole_en = 1'b0;
  logic        int_hit;
  logic [1:0]  bank;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_page_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctrl(ctrl), .mode(mode),
    .hole_en(hole_en), .int_hit(int_hit), .bank(bank)
  );

  task automatic check(input string req, input logic ei, input logic [1:0] eb);
    total++;
    if (int_hit !== ei || bank !== eb) begin
      bad++;
      $display("FAIL %s: int_hit=%b bank=%0d expected int_hit=%b bank=%0d",
               req, int_hit, bank, ei, eb);
    end
  endtask

  task automatic apply(input vec_t v);
    addr = v.a; ctrl = v.c; mode = v.m; hole_en = v.h;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    apply(V[0]);
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", 1'b1, 2'd0);
    apply(V[4]);
    #5;
    check("R2", 1'b1, 2'd0);
    @(negedge clk);
    check("R2", 1'b0, 2'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(V[i]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", V[i].r, i), V[i].ei, V[i].eb);
    end

    apply(V[2]);
    @(negedge clk);
    check("R4", 1'b1, 2'd3);
    #3 rst_n = 1'b0;
    #2;
    check("R1", 1'b0, 2'd0);
    @(negedge clk);
    check("R1", 1'b0, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", 1'b1, 2'd3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule